// File: doc/BRIEF.md
# Filtered Pin Edge Detector

This block watches one external input pin for a timer. It brings the raw pin into the system clock domain through a two-flop synchronizer. A filter then accepts a new level only after two consecutive samples agree on it, so short glitches are rejected.

The sampling rate depends on how the timer uses the edge:

- **Count-clock use:** a sample is taken on every system clock cycle.
- **Capture-trigger use:** a sample is taken only on cycles where the prescaler's sampling enable is high.

A two-bit selector picks which edges of the filtered level are valid. The choices are rising, falling, both or none. Each valid edge produces a pulse one system clock cycle wide.

A run input models the timer's run/stop state, and no pulse is produced while it is low.

- **Before the first run after reset:** the filter is frozen with its stored level at 0. If the pin is already high when the timer is first started and rising edges are selected, a rising pulse is therefore reported.
- **After the first run:** the filter keeps tracking the pin even while stopped. Restarting the timer with the pin high therefore reports no edge.

Top module: `pin_edge_filter`

## Requirements
- R1: After reset, `level_o` is 0 and `edge_pulse_o` is 0.
- R2: The filtered level takes a new value only after two consecutive samples show that value. An excursion seen on a single sample leaves `level_o` unchanged and produces no pulse.
- R3: With `count_mode_i`=1, a sample is taken every cycle. A pin change set up before clock edge k appears on `level_o`, together with any selected pulse, after edge k+3.
- R4: With `count_mode_i`=0, samples are taken only at clock edges where `samp_tick_i` is 1. The level changes at the second such sampling edge that sees the new synchronized value.
- R5: `edge_sel_i` encoding: 2'b00 gives no edges, 2'b01 gives rising only, 2'b10 gives falling only, and 2'b11 gives both. An edge that is not selected still updates `level_o`.
- R6: `edge_pulse_o` is never high for two cycles in a row.
- R7: While `run_i` is 0, `edge_pulse_o` stays 0 on the following cycle. Once the block has run at least once, `level_o` keeps following the pin while stopped.
- R8: If the pin is high after reset and rising or both edges are selected, the first assertion of `run_i` yields one rising pulse.
- R9: When `run_i` is re-asserted after a stop with the pin high and `level_o` already 1, no pulse is produced.
- R10: Before the first assertion of `run_i` after reset, `level_o` holds its value 0 whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw external pin, asynchronous |
| run_i | input | 1 | Timer run (1) / stop (0) |
| count_mode_i | input | 1 | 1: edge used as count clock (sample every cycle); 0: capture trigger (sample on tick) |
| samp_tick_i | input | 1 | Prescaler sampling enable for capture use |
| edge_sel_i | input | 2 | Valid-edge selection, encoding as in R5 |
| level_o | output | 1 | Filtered pin level |
| edge_pulse_o | output | 1 | One-cycle valid-edge pulse |

## Verification
In count mode a pin change driven after edge c is visible at the ports after edge c+4. That delay is two synchronizer stages, one first-sample stage and one confirming-sample stage. In capture mode the visible edge is the second tick-enabled edge at or after c+3.

On the first run with the synchronized level already high, the pulse follows two edges after `run_i` rises. The driver task computes the due cycle for each stimulus and queues it. A monitor samples the outputs on the falling clock edge and flags any pulse that comes early, comes late, is missing, or is unexpected.

// File: rtl/pef_pkg.sv
package pef_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

endpackage

// File: rtl/pef_sync.sv
module pef_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pef_filter.sv
module pef_filter #(
    parameter int CONFIRM = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic track_en,
    input  logic din,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CNT_W = $clog2(CONFIRM + 1);

    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (track_en && sample_en) begin
            if (din != st_q.level) begin
                if (st_q.cnt == CNT_W'(CONFIRM - 1)) begin
                    st_d.level = din;
                    st_d.cnt   = '0;
                    rise_o     = din;
                    fall_o     = !din;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;

    // R2: a new level is always the value just sampled, on an enabled sample
    a_r2_level_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level != $past(st_q.level)) |->
            ($past(din) == st_q.level && $past(track_en) && $past(sample_en)));
endmodule

// File: rtl/pef_edge.sv
module pef_edge
    import pef_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  edge_sel_e sel_i,
    input  logic      rise_i,
    input  logic      fall_i,
    output logic      pulse_o
);
    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = 1'b0;
        if (run_i) begin
            unique case (sel_i)
                EDGE_RISE: pulse_d = rise_i;
                EDGE_FALL: pulse_d = fall_i;
                EDGE_BOTH: pulse_d = rise_i | fall_i;
                default:   pulse_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
    end

    assign pulse_o = pulse_q;

    // R6
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
    // R7
    a_r7_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !pulse_q);
    // R5
    a_r5_none_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == EDGE_NONE) |=> !pulse_q);
endmodule

// File: rtl/pin_edge_filter.sv
module pin_edge_filter
    import pef_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CONFIRM     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       run_i,
    input  logic       count_mode_i,
    input  logic       samp_tick_i,
    input  logic [1:0] edge_sel_i,
    output logic       level_o,
    output logic       edge_pulse_o
);
    logic pin_sync;
    logic armed_d, armed_q;
    logic track_en, sample_en;
    logic rise, fall;

    pef_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_i),
        .dout (pin_sync)
    );

    always_comb begin
        armed_d   = armed_q | run_i;
        track_en  = run_i | armed_q;
        sample_en = count_mode_i | samp_tick_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    pef_filter #(.CONFIRM(CONFIRM)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(sample_en),
        .track_en (track_en),
        .din      (pin_sync),
        .level_o  (level_o),
        .rise_o   (rise),
        .fall_o   (fall)
    );

    pef_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_i),
        .sel_i  (edge_sel_e'(edge_sel_i)),
        .rise_i (rise),
        .fall_i (fall),
        .pulse_o(edge_pulse_o)
    );

    // R10: frozen at 0 until the first run
    a_r10_frozen_before_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !run_i) |=> (level_o == 1'b0));
endmodule

// File: tb/tb_pin_edge_filter.sv
module tb_pin_edge_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_i = 1'b1;
    logic       run_i = 1'b0;
    logic       count_mode_i = 1'b1;
    logic       samp_tick_i = 1'b0;
    logic [1:0] edge_sel_i = 2'b01;
    logic       level_o, edge_pulse_o;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    prev_pulse = 1'b0;
    int    exp_q[$];
    string tag_q[$];
    string phase = "R1";

    always #2.5 clk = ~clk;   // 200 MHz

    pin_edge_filter dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .run_i(run_i),
        .count_mode_i(count_mode_i), .samp_tick_i(samp_tick_i),
        .edge_sel_i(edge_sel_i), .level_o(level_o), .edge_pulse_o(edge_pulse_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // prescaler tick: high in cycles where cyc%4==0, so sampled at edges N with N%4==1
    always @(negedge clk) samp_tick_i <= (cyc % 4 == 0);

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_test();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int capture_due(int c);
        int n = c + 3;
        while (n % 4 != 1) n++;
        return n + 4;
    endfunction

    // driver: change pin now, queue the due cycle if a pulse is expected
    task automatic drive_pin(bit v, bit expect_pulse, string req);
        pin_i = v;
        if (expect_pulse) begin
            exp_q.push_back(count_mode_i ? cyc + 4 : capture_due(cyc));
            tag_q.push_back(req);
        end
        phase = req;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                check(1'b0, tag_q[0], 0, 1);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            if (edge_pulse_o) begin
                if (prev_pulse) check(1'b0, "R6", 1, 0);
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    check(1'b1, tag_q[0], 1, 1);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end else begin
                    check(1'b0, phase, 1, 0);
                end
            end
            prev_pulse = edge_pulse_o;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_test();
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        check(level_o == 1'b0 && edge_pulse_o == 1'b0, "R1", level_o, 0);
        phase = "R10";
        wait_cyc(10);
        check(level_o == 1'b0, "R10", level_o, 0);

        // R8: first run with pin high gives a rising pulse two edges later
        run_i = 1'b1;
        exp_q.push_back(cyc + 2); tag_q.push_back("R8");
        phase = "R8";
        wait_cyc(10);
        check(level_o == 1'b1, "R8", level_o, 1);

        // R7: stopped, no pulses, level still tracks
        run_i = 1'b0;
        edge_sel_i = 2'b11;
        drive_pin(1'b0, 1'b0, "R7");
        wait_cyc(10);
        check(level_o == 1'b0, "R7", level_o, 0);
        drive_pin(1'b1, 1'b0, "R7");
        wait_cyc(10);
        check(level_o == 1'b1, "R7", level_o, 1);

        // R9: re-enable with pin high, no pulse
        run_i = 1'b1;
        phase = "R9";
        wait_cyc(10);
        check(level_o == 1'b1, "R9", level_o, 1);

        // R3: count mode latency, both edges
        drive_pin(1'b0, 1'b1, "R3");
        wait_cyc(10);
        drive_pin(1'b1, 1'b1, "R3");
        wait_cyc(10);

        // R5: edge selection
        edge_sel_i = 2'b01;
        drive_pin(1'b0, 1'b0, "R5");
        wait_cyc(10);
        check(level_o == 1'b0, "R5", level_o, 0);
        drive_pin(1'b1, 1'b1, "R5");
        wait_cyc(10);
        edge_sel_i = 2'b10;
        drive_pin(1'b0, 1'b1, "R5");
        wait_cyc(10);
        drive_pin(1'b1, 1'b0, "R5");
        wait_cyc(10);
        edge_sel_i = 2'b00;
        drive_pin(1'b0, 1'b0, "R5");
        wait_cyc(10);
        drive_pin(1'b1, 1'b0, "R5");
        wait_cyc(10);
        check(level_o == 1'b1, "R5", level_o, 1);

        // R2: one-cycle glitch rejected, two-cycle excursion accepted
        edge_sel_i = 2'b11;
        drive_pin(1'b0, 1'b0, "R2");
        wait_cyc(1);
        drive_pin(1'b1, 1'b0, "R2");
        wait_cyc(10);
        check(level_o == 1'b1, "R2", level_o, 1);
        drive_pin(1'b0, 1'b1, "R2");
        wait_cyc(2);
        drive_pin(1'b1, 1'b1, "R2");
        wait_cyc(10);

        // R4: capture mode, samples on tick only
        count_mode_i = 1'b0;
        wait_cyc(3);
        drive_pin(1'b0, 1'b1, "R4");
        wait_cyc(16);
        check(level_o == 1'b0, "R4", level_o, 0);
        wait_cyc(1);
        drive_pin(1'b1, 1'b1, "R4");
        wait_cyc(16);
        wait_cyc(2);
        drive_pin(1'b0, 1'b0, "R4");
        wait_cyc(3);
        drive_pin(1'b1, 1'b0, "R4");
        wait_cyc(16);
        check(level_o == 1'b1, "R4", level_o, 1);

        check(exp_q.size() == 0, "R3", exp_q.size(), 0);
        finish_test();
    end
endmodule